// File: doc/BRIEF.md
# Eight-bit Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small accumulator machine. A combinational core takes a 3-bit operation code, the current accumulator, an operand byte and the current flag byte. It computes a result and six architectural flags: sign, zero, half-carry, parity/overflow, subtract and carry. A thin clocked wrapper holds the accumulator and the flag byte. On every clock edge where `op_en` is high, it writes the new values back. Operand fetch, instruction decode and memory addressing belong to the surrounding datapath.

Eight operations are provided: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. Each operation has its own rules for the flags. The parity/overflow bit reports signed overflow for arithmetic and even parity for the logic operations. AND forces half-carry to 1, while XOR and OR clear it. Compare sets the flags exactly as a subtraction would, but the accumulator keeps its value. The flag byte is packed with S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0. Bits 5 and 3 are spare and are never modified.

Top module: `acc_alu`

## Requirements
- R1: With `op_code` 3'b000 (add), the accumulator becomes (A + operand) mod 256. C is the carry out of bit 7, and H is the carry out of bit 3.
- R2: With `op_code` 3'b001 (add with carry), the incoming C flag is added as well: A + operand + C. H and C are formed as in R1.
- R3: With `op_code` 3'b010 (subtract), the accumulator becomes A − operand. With 3'b011 (subtract with borrow), it becomes A − operand − C. C is set when the full-width result is negative, that is, on a borrow out of bit 7. H is set on a borrow into bit 4.
- R4: With `op_code` 3'b111 (compare), the flags are the ones subtract would give, and the accumulator is left unchanged.
- R5: For add, add with carry, subtract, subtract with borrow and compare, P/V (flag bit 2) is set exactly when the two's-complement result overflows the signed 8-bit range.
- R6: N (flag bit 1) is 0 after add and add with carry. It is 1 after subtract, subtract with borrow and compare.
- R7: With `op_code` 3'b100, 3'b101 and 3'b110, the accumulator becomes A AND, XOR and OR operand respectively. P/V is 1 when the result has an even number of 1 bits.
- R8: After AND, H is 1, N is 0 and C is 0. After XOR and OR, H, N and C are all 0.
- R9: S (flag bit 7) equals bit 7 of the operation's result. Z (flag bit 6) is 1 exactly when that 8-bit result is zero. For compare, the result is the difference.
- R10: Flag bits 5 and 3 keep their value through every operation.
- R11: The accumulator and flags change one clock after an edge where `op_en` is high. While `op_en` is low, both hold their value.
- R12: While `rst_n` is low, the accumulator and the flag byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_en | input | 1 | Perform `op_code` on this edge |
| op_code | input | 3 | Operation select (encoding in R1–R8) |
| operand | input | 8 | Second operand byte |
| acc | output | 8 | Registered accumulator |
| flags | output | 8 | Registered flag byte {S,Z,spare,H,spare,P/V,N,C} |

## Verification
Every result of an operation enabled at one rising edge is visible on `acc` and `flags` straight after that edge. No later cycle adds anything to it. The bench drives an operation at a falling edge and steps its behavioural model once for that operation. At the next falling edge it compares the accumulator and each flag field separately, so a failure names the rule it broke. Idle cycles are compared the same way against an unchanged model, which confirms that nothing moves without `op_en`.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [2:0] {
      ALU_ADD = 3'b000,
      ALU_ADC = 3'b001,
      ALU_SUB = 3'b010,
      ALU_SBC = 3'b011,
      ALU_AND = 3'b100,
      ALU_XOR = 3'b101,
      ALU_OR  = 3'b110,
      ALU_CMP = 3'b111
   } alu_op_e;

   localparam int FLAG_W = 8;
   localparam int FB_S   = 7;
   localparam int FB_Z   = 6;
   localparam int FB_SP5 = 5;
   localparam int FB_H   = 4;
   localparam int FB_SP3 = 3;
   localparam int FB_PV  = 2;
   localparam int FB_N   = 1;
   localparam int FB_C   = 0;

   typedef struct packed {
      logic sign;
      logic zero;
      logic half;
      logic pv;
      logic neg;
      logic carry;
   } alu_flags_t;

   function automatic logic op_is_subtract(input alu_op_e op);
      return (op == ALU_SUB) || (op == ALU_SBC) || (op == ALU_CMP);
   endfunction

   function automatic logic op_is_logic(input alu_op_e op);
      return (op == ALU_AND) || (op == ALU_XOR) || (op == ALU_OR);
   endfunction

   function automatic logic op_uses_carry(input alu_op_e op);
      return (op == ALU_ADC) || (op == ALU_SBC);
   endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int W      = 8,
   parameter int HALF_W = 4,
   parameter bit SPLIT  = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         subtract,
   input  logic         carry_in,
   output logic [W-1:0] sum,
   output logic         half_out,
   output logic         carry_out,
   output logic         overflow
);
   localparam int HI_W = W - HALF_W;

   if (W < 2) begin : g_bad_width
      $error("acc_alu_addsub: W must be at least 2");
   end
   if (HALF_W < 1 || HALF_W >= W) begin : g_bad_half
      $error("acc_alu_addsub: HALF_W must lie in 1..W-1");
   end

   logic [W-1:0] b_eff;
   logic         c_eff;
   logic         c_half;
   logic         c_top;

   // subtraction as a + ~b + ~borrow_in
   assign b_eff = subtract ? ~b : b;
   assign c_eff = carry_in ^ subtract;

   if (SPLIT) begin : g_split
      logic [HALF_W:0] lo;
      logic [HI_W:0]   hi;
      assign lo = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
                + {{HALF_W{1'b0}}, c_eff};
      assign hi = {1'b0, a[W-1:HALF_W]} + {1'b0, b_eff[W-1:HALF_W]}
                + {{HI_W{1'b0}}, lo[HALF_W]};
      assign sum    = {hi[HI_W-1:0], lo[HALF_W-1:0]};
      assign c_half = lo[HALF_W];
      assign c_top  = hi[HI_W];
   end else begin : g_flat
      logic [W:0] full;
      assign full   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
      assign sum    = full[W-1:0];
      assign c_top  = full[W];
      // carry into bit HALF_W recovered from the sum bit
      assign c_half = a[HALF_W] ^ b_eff[HALF_W] ^ full[HALF_W];
   end

   // carries become borrows for subtraction
   assign half_out  = c_half ^ subtract;
   assign carry_out = c_top ^ subtract;
   assign overflow  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
   parameter int W        = 8,
   parameter bit PAR_TREE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   sel,
   output logic [W-1:0] res,
   output logic         parity_even
);
   if (W < 1) begin : g_bad_width
      $error("acc_alu_logic: W must be positive");
   end

   always_comb begin
      unique case (sel)
         2'b00:   res = a & b;
         2'b01:   res = a ^ b;
         default: res = a | b;
      endcase
   end

   if (PAR_TREE) begin : g_chain
      logic [W:0] chain;
      assign chain[0] = 1'b0;
      for (genvar gi = 0; gi < W; gi++) begin : g_bit
         assign chain[gi+1] = chain[gi] ^ res[gi];
      end
      assign parity_even = ~chain[W];
   end else begin : g_reduce
      assign parity_even = ~^res;
   end

endmodule

// File: rtl/acc_alu_flagpack.sv
module acc_alu_flagpack
   import acc_alu_pkg::*;
(
   input  alu_flags_t         f,
   input  logic [FLAG_W-1:0]  flags_in,
   output logic [FLAG_W-1:0]  flags_out
);
   always_comb begin
      flags_out        = flags_in;   // spare bits ride through
      flags_out[FB_S]  = f.sign;
      flags_out[FB_Z]  = f.zero;
      flags_out[FB_H]  = f.half;
      flags_out[FB_PV] = f.pv;
      flags_out[FB_N]  = f.neg;
      flags_out[FB_C]  = f.carry;
   end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int W           = 8,
   parameter int HALF_W      = 4,
   parameter bit SPLIT_ADDER = 1'b1,
   parameter bit PAR_TREE    = 1'b0
) (
   input  alu_op_e            op,
   input  logic [W-1:0]       acc_in,
   input  logic [W-1:0]       operand,
   input  logic [FLAG_W-1:0]  flags_in,
   output logic [W-1:0]       acc_out,
   output logic [FLAG_W-1:0]  flags_out
);
   logic         is_sub;
   logic         is_logic;
   logic         cin;
   logic [W-1:0] as_sum;
   logic         as_half;
   logic         as_carry;
   logic         as_ovf;
   logic [W-1:0] lg_res;
   logic         lg_par;
   logic [W-1:0] res;
   alu_flags_t   fl;

   assign is_sub   = op_is_subtract(op);
   assign is_logic = op_is_logic(op);
   assign cin      = op_uses_carry(op) & flags_in[FB_C];

   acc_alu_addsub #(
      .W      (W),
      .HALF_W (HALF_W),
      .SPLIT  (SPLIT_ADDER)
   ) u_addsub (
      .a         (acc_in),
      .b         (operand),
      .subtract  (is_sub),
      .carry_in  (cin),
      .sum       (as_sum),
      .half_out  (as_half),
      .carry_out (as_carry),
      .overflow  (as_ovf)
   );

   acc_alu_logic #(
      .W        (W),
      .PAR_TREE (PAR_TREE)
   ) u_logic (
      .a           (acc_in),
      .b           (operand),
      .sel         (op[1:0]),
      .res         (lg_res),
      .parity_even (lg_par)
   );

   assign res = is_logic ? lg_res : as_sum;

   always_comb begin
      fl.sign  = res[W-1];
      fl.zero  = (res == '0);
      fl.half  = is_logic ? (op == ALU_AND) : as_half;
      fl.pv    = is_logic ? lg_par : as_ovf;
      fl.neg   = is_sub;
      fl.carry = is_logic ? 1'b0 : as_carry;
   end

   acc_alu_flagpack u_pack (
      .f         (fl),
      .flags_in  (flags_in),
      .flags_out (flags_out)
   );

   assign acc_out = (op == ALU_CMP) ? acc_in : res;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter int          HALF_W      = 4,
   parameter bit          SPLIT_ADDER = 1'b1,
   parameter bit          PARITY_TREE = 1'b0,
   parameter logic [7:0]  FLAG_RST    = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_en,
   input  logic [2:0]        op_code,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] acc,
   output logic [7:0]        flags
);
   if (DATA_W < 2) begin : g_bad_data
      $error("acc_alu: DATA_W must be at least 2");
   end
   if (HALF_W < 1 || HALF_W >= DATA_W) begin : g_bad_half
      $error("acc_alu: HALF_W must lie in 1..DATA_W-1");
   end

   alu_op_e           op;
   logic [DATA_W-1:0] acc_nxt;
   logic [7:0]        flags_nxt;

   assign op = alu_op_e'(op_code);

   acc_alu_core #(
      .W           (DATA_W),
      .HALF_W      (HALF_W),
      .SPLIT_ADDER (SPLIT_ADDER),
      .PAR_TREE    (PARITY_TREE)
   ) u_core (
      .op        (op),
      .acc_in    (acc),
      .operand   (operand),
      .flags_in  (flags),
      .acc_out   (acc_nxt),
      .flags_out (flags_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         flags <= FLAG_RST;
      end else if (op_en) begin
         acc   <= acc_nxt;
         flags <= flags_nxt;
      end
   end

   // compare leaves the accumulator alone (R4)
   p_cmp_keeps_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op == ALU_CMP) |=> (acc == $past(acc)));

   // subtract-type operations raise N (R6)
   p_sub_sets_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && (op == ALU_SUB || op == ALU_SBC || op == ALU_CMP)) |=> flags[FB_N]);

   // add-type operations clear N (R6)
   p_add_clears_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && (op == ALU_ADD || op == ALU_ADC)) |=> !flags[FB_N]);

   // logic operations clear carry and N (R8)
   p_logic_clears_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && (op == ALU_AND || op == ALU_XOR || op == ALU_OR))
      |=> (!flags[FB_C] && !flags[FB_N]));

   // AND raises half-carry, XOR/OR drop it (R8)
   p_and_sets_h_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op == ALU_AND) |=> flags[FB_H]);
   p_xor_or_clear_h_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && (op == ALU_XOR || op == ALU_OR)) |=> !flags[FB_H]);

   // S and Z agree with the written accumulator (R9)
   p_zero_tracks_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op != ALU_CMP) |=> (flags[FB_Z] == (acc == '0)));
   p_sign_tracks_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op != ALU_CMP) |=> (flags[FB_S] == acc[DATA_W-1]));

   // spare flag bits never move (R10)
   p_spare_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_en |=> ($stable(flags[FB_SP5]) && $stable(flags[FB_SP3])));

   // no update without op_en (R11)
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !op_en |=> ($stable(acc) && $stable(flags)));

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       op_en;
   logic [2:0] op_code;
   logic [7:0] operand;
   logic [7:0] acc;
   logic [7:0] flags;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   bit [7:0] m_acc;
   bit [7:0] m_flg;

   always #5 clk = ~clk;

   acc_alu u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_en   (op_en),
      .op_code (op_code),
      .operand (operand),
      .acc     (acc),
      .flags   (flags)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // behavioural reference for one enabled operation
   task automatic model(input int op, input int b);
      int a, c, cin, r, lo, sa, sb, sv, res, ones;
      bit s, z, h, pv, n, cy;
      a = m_acc; c = m_flg[0];
      sa = (a >= 128) ? a - 256 : a;
      sb = (b >= 128) ? b - 256 : b;
      h = 0; pv = 0; n = 0; cy = 0; r = 0;
      if (op <= 1) begin
         cin = (op == 1) ? c : 0;
         r  = a + b + cin;
         lo = (a % 16) + (b % 16) + cin;
         h  = (lo > 15); cy = (r > 255);
         sv = sa + sb + cin;
         pv = (sv > 127) || (sv < -128);
      end else if (op == 2 || op == 3 || op == 7) begin
         cin = (op == 3) ? c : 0;
         r  = a - b - cin;
         lo = (a % 16) - (b % 16) - cin;
         h  = (lo < 0); cy = (r < 0); n = 1;
         sv = sa - sb - cin;
         pv = (sv > 127) || (sv < -128);
      end else begin
         if (op == 4) r = a & b;
         else if (op == 5) r = a ^ b;
         else r = a | b;
         h = (op == 4);
         ones = 0;
         for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
         pv = (ones % 2 == 0);
      end
      res = r & 255;
      s = (res >= 128); z = (res == 0);
      if (op != 7) m_acc = res[7:0];
      m_flg = {s, z, m_flg[5], h, m_flg[3], pv, n, cy};
   endtask

   function automatic string acc_tag(input int op);
      case (op)
         0: return "R1";
         1: return "R2";
         2, 3: return "R3";
         7: return "R4";
         default: return "R7";
      endcase
   endfunction

   task automatic compare(input bit idle, input int op);
      string ta, tc, th, tp;
      if (idle) begin
         ta = "R11"; tc = "R11"; th = "R11"; tp = "R11";
      end else begin
         ta = acc_tag(op);
         tc = (op <= 1) ? "R1" : ((op >= 4 && op <= 6) ? "R8" : "R3");
         th = tc;
         tp = (op >= 4 && op <= 6) ? "R7" : "R5";
      end
      check(ta, "acc", acc, m_acc);
      check(idle ? "R11" : "R9", "sign", flags[7], m_flg[7]);
      check(idle ? "R11" : "R9", "zero", flags[6], m_flg[6]);
      check(th, "half", flags[4], m_flg[4]);
      check(tp, "p/v", flags[2], m_flg[2]);
      check(idle ? "R11" : "R6", "subtract", flags[1], m_flg[1]);
      check(tc, "carry", flags[0], m_flg[0]);
      check(idle ? "R11" : "R10", "spare bits", {flags[5], flags[3]}, {m_flg[5], m_flg[3]});
   endtask

   // called at a falling edge; result sampled at the next falling edge
   task automatic run_op(input int op, input int b);
      op_en   = 1'b1;
      op_code = op[2:0];
      operand = b[7:0];
      model(op, b);
      @(negedge clk);
      compare(1'b0, op);
      op_en = 1'b0;
   endtask

   task automatic idle(input int junk_op, input int junk_b);
      op_en   = 1'b0;
      op_code = junk_op[2:0];
      operand = junk_b[7:0];
      @(negedge clk);
      compare(1'b1, junk_op);
   endtask

   task automatic load_acc(input int v);
      run_op(4, 0);
      run_op(6, v);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      report();
   end

   initial begin
      bit [15:0] lfsr;
      rst_n = 1'b0; op_en = 1'b0; op_code = 3'd0; operand = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12 reset state
      check("R12", "acc at reset", acc, 0);
      check("R12", "flags at reset", flags, 0);
      rst_n = 1'b1;
      m_acc = 0; m_flg = 0;
      @(negedge clk);
      compare(1'b1, 0);

      // R1 / R5 add corners
      load_acc(8'h7F); run_op(0, 8'h01);      // signed overflow, half carry
      load_acc(8'h80); run_op(0, 8'h80);      // carry, overflow, zero
      load_acc(8'h0F); run_op(0, 8'h01);      // half carry only
      // R2 add with carry, carry set by previous op
      load_acc(8'hFF); run_op(0, 8'h01); run_op(1, 8'h00);
      load_acc(8'h10); run_op(0, 8'hF0); run_op(1, 8'h7E);
      // R3 / R5 subtract corners
      load_acc(8'h80); run_op(2, 8'h01);      // overflow
      load_acc(8'h00); run_op(2, 8'h01);      // borrow and half borrow
      run_op(3, 8'h00);                       // borrow consumed
      load_acc(8'h10); run_op(2, 8'h20); run_op(3, 8'h0F);
      // R4 compare equal / lower / higher
      load_acc(8'h42); run_op(7, 8'h42); run_op(7, 8'h43); run_op(7, 8'h01);
      // R7 / R8 logic
      load_acc(8'hF0); run_op(4, 8'h0F);      // zero, even parity, H=1
      load_acc(8'h01); run_op(6, 8'h00);      // odd parity
      load_acc(8'hAA); run_op(5, 8'hFF);
      run_op(5, 8'h55);
      // R11 idle cycles with changing inputs
      idle(0, 8'hFF); idle(2, 8'h33); idle(7, 8'h00);

      lfsr = 16'hACE1;
      for (int k = 0; k < 1500; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[15:13] == 3'b000) idle(int'(lfsr[2:0]), int'(lfsr[11:4]));
         else run_op(int'(lfsr[2:0]), int'(lfsr[11:4]));
      end
      report();
   end

endmodule